// File: doc/BRIEF.md
# Frame Buffer Burst Fetcher

This block streams a frame buffer out of memory for a raster display. Software supplies the byte address of the first 32-bit word and an inclusive last-word address, called the ceiling. The block issues burst read requests on a request/grant port and takes the returned words one per response strobe. The words go to one of two places. Words from the leading palette region go out on a palette port. The remaining pixel words are pushed into a small internal FIFO, which the display timing logic pops.

A power-of-two code sets the burst length. A new burst is requested only when the FIFO can hold a whole burst. The final burst of a frame is shortened so that it ends exactly at the ceiling. The block then pulses frame-done and starts again at the base address.

A load-mode input selects what is fetched:
- **Palette-and-data:** the palette region and the pixel data.
- **Palette-only:** just the palette region, after which fetching stops until the block is re-enabled.

A pop from an empty FIFO sets a sticky underflow flag, which can raise an interrupt. To recover, clear the enable, clear the flag, and enable again. Dropping the enable flushes the FIFO and discards any words still in flight.

Top module: `fb_dma_fetch`

## Requirements
- R1: Burst code values 0, 1, 2, 3 and 4 select bursts of 1, 2, 4, 8 and 16 words. No request has a length of zero or a length greater than the selected burst, and at least one request of each frame uses the full burst length.
- R2: Burst code values 5, 6 and 7 are invalid; while one of them is applied, no read request is raised and no frame-done pulse appears.
- R3: One frame requests words from the base address through the ceiling address inclusive, in ascending order, 4 bytes per word. The last request of the frame ends exactly at the ceiling, or at the palette end in palette-only mode.
- R4: On the cycle after the ceiling word is returned, frame_done pulses for one cycle. The next request, and the next palette word delivered, start again at the base address.
- R5: The palette is the first part of the buffer. It holds 8 words (32 bytes) when pal_large is 0 and 128 words (512 bytes) when pal_large is 1. Palette words appear on pal_valid/pal_data one cycle after their response and never enter the pixel FIFO.
- R6: pal_only = 0 loads the palette and then pushes the remaining words to the pixel FIFO in address order. pal_only = 1 loads the palette only: frame_done pulses once, no pixel word is pushed, and no further request is issued until en is cycled.
- R7: A burst is requested only when the FIFO free space (depth minus occupancy) is at least the selected burst length. With the default depth of 32 and a 16-word burst, a stalled consumer allows exactly two bursts per frame start with the small palette.
- R8: A px_pop while en is 1 and the FIFO is empty sets ufl_flag on the next cycle. A pop while en is 0 does not set it. ufl_irq equals ufl_flag AND ufl_ie, registered. A ufl_clr pulse clears the flag unless a new underflow occurs in the same cycle.
- R9: While en is 0 the FIFO is empty and rd_req is low. Words of a burst that was in flight when en fell are discarded even if they arrive after en returns. Re-enabling restarts at the base address.
- R10: While en is 1, a raised rd_req stays high with the same rd_addr and rd_len until a cycle in which rd_gnt is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Fetch enable; low flushes and rewinds |
| base_addr | input | 32 | Byte address of the first buffer word |
| ceil_addr | input | 32 | Byte address of the last buffer word (inclusive) |
| burst_code | input | 3 | Burst length code, length = 2^code for codes 0..4 |
| pal_only | input | 1 | 0: palette and data, 1: palette only |
| pal_large | input | 1 | 0: 8-word palette, 1: 128-word palette |
| ufl_ie | input | 1 | Underflow interrupt enable |
| ufl_clr | input | 1 | Clears the underflow flag |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | 32 | Byte address of the first word of the burst |
| rd_len | output | 5 | Words in the burst |
| rd_gnt | input | 1 | Memory accepts the request this cycle |
| rsp_valid | input | 1 | Returned word strobe |
| rsp_data | input | 32 | Returned word |
| pal_valid | output | 1 | Palette word strobe |
| pal_data | output | 32 | Palette word |
| px_valid | output | 1 | Pixel FIFO not empty |
| px_data | output | 32 | Pixel word at FIFO head |
| px_pop | input | 1 | Consumer takes the head word |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame |
| ufl_flag | output | 1 | Sticky underflow flag |
| ufl_irq | output | 1 | Underflow interrupt |

## Verification
The bench drives a set of buffer shapes. In one, 21 words are fetched with 8-word bursts, so the last burst must shrink to 5 words. A design that rounded the last burst up would read past the ceiling, and one that wrapped early would restart the palette stream in mid-frame. In palette-only mode the bench watches for a stray pixel push or a second request after the palette end; either would show that the stop condition was skipped.

With the consumer stalled, a design that checked for one free word instead of a whole burst would request a third burst and overflow the FIFO. The bench also drops en while a burst is in flight and re-enables before that burst's responses arrive. If the discard were lost, stale addresses would appear on the palette port ahead of the base word.

// File: rtl/fb_dma_pkg.sv
`timescale 1ns/1ps
package fb_dma_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;
  localparam int LEN_W    = MAX_CODE + 1;

  typedef logic [CODE_W-1:0] burst_code_t;
  typedef logic [LEN_W-1:0]  burst_len_t;

  function automatic logic code_ok(burst_code_t c);
    return int'(c) <= MAX_CODE;
  endfunction

  // length in words for a legal code, zero for an illegal one
  function automatic burst_len_t code_len(burst_code_t c);
    burst_len_t n;
    n = '0;
    for (int k = 0; k <= MAX_CODE; k++)
      if (int'(c) == k) n = burst_len_t'(1) << k;
    return n;
  endfunction
endpackage

// File: rtl/fb_dma_fifo.sv
`timescale 1ns/1ps
module fb_dma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          valid,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign valid = (count != '0);
  assign do_wr = push && !full && !flush;
  assign do_rd = pop && valid && !flush;
  assign rdata = mem[rp];

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R7
  fifo_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> !full)
    else $error("fifo_ovf_chk: push into full pixel FIFO");
endmodule

// File: rtl/fb_dma_req.sv
`timescale 1ns/1ps
module fb_dma_req
  import fb_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     lim,
  input  burst_code_t       code,
  input  logic              pal_only,
  input  logic [FREE_W-1:0] free,
  input  logic              rsp_valid,
  input  logic              rd_gnt,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output burst_len_t        rd_len,
  output logic              discard
);
  logic [AW-1:0] nxt, rem_w, burst_end;
  logic          busy, drop_q, stopped, last_q;
  burst_len_t    left, blen, take;
  logic          accept, go, last_rsp;

  assign blen      = code_len(code);
  assign rem_w     = ((lim - nxt) >> 2) + AW'(1);
  assign take      = (rem_w < AW'(blen)) ? rem_w[LEN_W-1:0] : blen;
  assign accept    = rd_req && rd_gnt;
  assign go        = en && !busy && !rd_req && !stopped && code_ok(code) &&
                     (free >= FREE_W'(blen));
  assign last_rsp  = busy && rsp_valid && (left == burst_len_t'(1));
  assign burst_end = rd_addr + (AW'(rd_len) << 2) - AW'(4);
  assign discard   = !en || drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      rd_len  <= '0;
      nxt     <= '0;
      busy    <= 1'b0;
      drop_q  <= 1'b0;
      stopped <= 1'b0;
      last_q  <= 1'b0;
      left    <= '0;
    end else begin
      if (busy && rsp_valid) begin
        left <= left - burst_len_t'(1);
        if (last_rsp) begin
          busy   <= 1'b0;
          drop_q <= 1'b0;
        end
      end
      if (!en && busy && !last_rsp) drop_q <= 1'b1;

      if (accept) begin
        rd_req <= 1'b0;
        busy   <= 1'b1;
        left   <= rd_len;
        drop_q <= !en;
      end else if (!en) begin
        rd_req <= 1'b0;
      end else if (go) begin
        rd_req  <= 1'b1;
        rd_addr <= nxt;
        rd_len  <= take;
        last_q  <= (rem_w <= AW'(blen));
      end

      if (!en) begin
        nxt     <= base;
        stopped <= 1'b0;
      end else if (accept) begin
        nxt <= last_q ? base : burst_end + AW'(4);
        if (last_q && pal_only) stopped <= 1'b1;
      end
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_gnt && en) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)))
    else $error("rd_hold_chk: request dropped or changed before grant");
  // R1
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && en) |-> (rd_len != '0 && rd_len <= code_len(code)))
    else $error("burst_len_chk: burst length outside selected size");
  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && en) |-> (rd_addr >= base && burst_end <= lim))
    else $error("addr_range_chk: burst outside buffer window");
  // R2
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(code_ok(code)))
    else $error("bad_code_chk: request raised under an illegal code");
endmodule

// File: rtl/fb_dma_fetch.sv
`timescale 1ns/1ps
module fb_dma_fetch
  import fb_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int FIFO_DEPTH  = 32,
  parameter int PAL_S_WORDS = 8,
  parameter int PAL_L_WORDS = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] ceil_addr,
  input  logic [2:0]    burst_code,
  input  logic          pal_only,
  input  logic          pal_large,
  input  logic          ufl_ie,
  input  logic          ufl_clr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [4:0]    rd_len,
  input  logic          rd_gnt,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          pal_valid,
  output logic [DW-1:0] pal_data,
  output logic          px_valid,
  output logic [DW-1:0] px_data,
  input  logic          px_pop,
  output logic          frame_done,
  output logic          ufl_flag,
  output logic          ufl_irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [AW-1:0] pal_bytes, lim, raddr;
  logic [CW-1:0] fcount, ffree;
  logic          discard, take, is_pal, is_last, px_push, uf_hit, ufl_n;
  burst_len_t    len_w;

  assign pal_bytes = pal_large ? AW'(PAL_L_WORDS * 4) : AW'(PAL_S_WORDS * 4);
  assign lim       = pal_only ? (base_addr + pal_bytes - AW'(4)) : ceil_addr;
  assign ffree     = CW'(FIFO_DEPTH) - fcount;
  assign rd_len    = len_w;

  fb_dma_req #(.AW(AW), .FREE_W(CW)) u_req (
    .clk(clk), .rst(rst), .en(en), .base(base_addr), .lim(lim),
    .code(burst_code), .pal_only(pal_only), .free(ffree),
    .rsp_valid(rsp_valid), .rd_gnt(rd_gnt), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_len(len_w), .discard(discard)
  );

  // response side tracks the address of the next returned word
  assign take    = rsp_valid && !discard;
  assign is_pal  = (raddr - base_addr) < pal_bytes;
  assign is_last = (raddr == lim);
  assign px_push = take && !is_pal;

  fb_dma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(!en), .push(px_push), .wdata(rsp_data),
    .pop(px_pop), .rdata(px_data), .valid(px_valid), .count(fcount)
  );

  assign uf_hit = px_pop && !px_valid && en;
  assign ufl_n  = (ufl_flag && !ufl_clr) || uf_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      raddr      <= '0;
      pal_valid  <= 1'b0;
      pal_data   <= '0;
      frame_done <= 1'b0;
      ufl_flag   <= 1'b0;
      ufl_irq    <= 1'b0;
    end else begin
      if (!en)       raddr <= base_addr;
      else if (take) raddr <= is_last ? base_addr : raddr + AW'(4);
      pal_valid  <= take && is_pal;
      pal_data   <= rsp_data;
      frame_done <= take && is_last;
      ufl_flag   <= ufl_n;
      ufl_irq    <= ufl_n && ufl_ie;
    end
  end

  // R6
  palonly_px_chk: assert property (@(posedge clk) disable iff (rst)
    (px_push && en) |-> !pal_only)
    else $error("palonly_px_chk: pixel pushed in palette-only mode");
  // R8
  ufl_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ufl_flag) |-> $past(px_pop && en && !px_valid))
    else $error("ufl_set_chk: underflow flag set without empty pop");
  // R9
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !px_valid)
    else $error("flush_chk: FIFO holds data while disabled");
endmodule

// File: tb/fb_dma_fetch_tb.sv
`timescale 1ns/1ps
module fb_dma_fetch_tb;
  logic        clk = 0, rst = 1, en = 0;
  logic [31:0] base_addr = 0, ceil_addr = 0;
  logic [2:0]  burst_code = 0;
  logic        pal_only = 0, pal_large = 0, ufl_ie = 0, ufl_clr = 0;
  logic        rd_req, rd_gnt = 0, rsp_valid = 0;
  logic [31:0] rd_addr, rsp_data = 0, pal_data, px_data;
  logic [4:0]  rd_len;
  logic        pal_valid, px_valid, px_pop = 0, frame_done, ufl_flag, ufl_irq;

  fb_dma_fetch u_dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit chk_on = 0, pop_en = 0, force_pop = 0, stall = 0;
  int n_acc = 0, n_pal = 0, n_px = 0, n_fd = 0, n_ceil = 0, max_len = 0, cyc = 0;
  logic [31:0] exp_req, exp_pal, exp_px, lim_b, palb;
  int          blen;
  logic [31:0] q[$];
  bit          pend = 0;
  logic [31:0] paddr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (pend && en) chk(rd_req && rd_addr == paddr, "R10", rd_addr, paddr);
    pend = 0;
    if (q.size() > 0) begin rsp_valid = 1; rsp_data = q.pop_front(); end
    else rsp_valid = 0;
    rd_gnt = stall ? (cyc % 3 == 0) : 1'b1;
    if (rd_req && !rd_gnt && en) begin pend = 1; paddr = rd_addr; end
    if (rd_req && rd_gnt) begin
      for (int k = 0; k < int'(rd_len); k++) q.push_back(rd_addr + 32'(4 * k));
      if (chk_on && en) begin
        n_acc++;
        if (int'(rd_len) > max_len) max_len = int'(rd_len);
        chk(rd_addr == exp_req, "R3", rd_addr, exp_req);
        chk(rd_len != 0 && int'(rd_len) <= blen, "R1", rd_len, blen);
        chk(rd_addr + 32'(4 * int'(rd_len)) - 4 <= lim_b, "R3", rd_addr + 32'(4 * int'(rd_len)) - 4, lim_b);
        exp_req = (rd_addr + 32'(4 * int'(rd_len)) - 4 == lim_b) ? base_addr
                                                                : rd_addr + 32'(4 * int'(rd_len));
      end
    end
  end

  // observer and consumer
  initial forever begin
    @(negedge clk);
    px_pop = (pop_en && px_valid) || force_pop;
    if (chk_on) begin
      if (frame_done) n_fd++;
      if (pal_valid) begin
        n_pal++;
        chk(pal_data == exp_pal, "R5", pal_data, exp_pal);
        exp_pal = (exp_pal + 4 == base_addr + palb) ? base_addr : exp_pal + 4;
      end
      if (pop_en && px_valid) begin
        n_px++;
        chk(px_data == exp_px, "R6", px_data, exp_px);
        if (px_data == ceil_addr) n_ceil++;
        exp_px = (exp_px == ceil_addr) ? base_addr + palb : exp_px + 4;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_fetch();
    @(posedge clk); #1 en = 0; chk_on = 0;
    cycles(3);
  endtask

  task automatic start(input logic [31:0] b, input int words, input int code,
                       input bit mode, input bit psel);
    base_addr = b; ceil_addr = b + 32'(4 * words) - 4;
    burst_code = 3'(code); pal_only = mode; pal_large = psel;
    palb = psel ? 32'd512 : 32'd32;
    lim_b = mode ? b + palb - 4 : ceil_addr;
    blen = (code <= 4) ? (1 << code) : 0;
    exp_req = b; exp_pal = b; exp_px = b + palb;
    n_acc = 0; n_pal = 0; n_px = 0; n_fd = 0; n_ceil = 0; max_len = 0;
    @(posedge clk); #1 en = 1; chk_on = 1;
  endtask

  task automatic wait_fd(input int n);
    for (int t = 0; t < 20000 && n_fd < n; t++) @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam int VB[NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5000, 32'h6000};
  localparam int VW[NV] = '{48, 21, 148, 13, 200, 50};
  localparam int VC[NV] = '{2, 3, 4, 0, 4, 1};
  localparam bit VM[NV] = '{0, 0, 0, 0, 1, 1};
  localparam bit VP[NV] = '{0, 0, 1, 0, 1, 0};

  initial begin
    #(190000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int acc_snap, pw;
    cycles(4);
    @(posedge clk); #1 rst = 0;
    cycles(1);
    chk(!rd_req && !px_valid && !pal_valid, "R9", {rd_req, px_valid, pal_valid}, 0);
    chk(!ufl_flag && !ufl_irq && !frame_done, "R8", {ufl_flag, ufl_irq, frame_done}, 0);

    pop_en = 1;
    for (int i = 0; i < NV; i++) begin
      stall = (i % 2 == 1);
      pw = VP[i] ? 128 : 8;
      start(VB[i], VW[i], VC[i], VM[i], VP[i]);
      if (!VM[i]) begin
        wait_fd(2);
        chk(n_fd == 2, "R4", n_fd, 2);
        chk(n_pal == 2 * pw, "R5", n_pal, 2 * pw);
        cycles(80);
        chk(n_ceil >= 2, "R3", n_ceil, 2);
        chk(max_len == (1 << VC[i]), "R1", max_len, 1 << VC[i]);
      end else begin
        wait_fd(1);
        acc_snap = n_acc;
        cycles(200);
        chk(n_fd == 1, "R6", n_fd, 1);
        chk(n_px == 0 && !px_valid, "R6", n_px, 0);
        chk(n_acc == acc_snap, "R6", n_acc, acc_snap);
        chk(n_pal == pw, "R5", n_pal, pw);
        chk(max_len == (1 << VC[i]), "R1", max_len, 1 << VC[i]);
      end
      stop_fetch();
    end
    stall = 0;

    // R2: illegal code
    start(32'h7000, 40, 5, 0, 0);
    cycles(100);
    chk(n_acc == 0 && n_fd == 0, "R2", n_acc, 0);
    stop_fetch();

    // R7: stalled consumer, 16-word bursts, depth 32
    pop_en = 0;
    start(32'h8000, 200, 4, 0, 0);
    cycles(200);
    chk(n_acc == 2, "R7", n_acc, 2);
    chk(px_valid, "R7", px_valid, 1);
    @(posedge clk); #1 en = 0; chk_on = 0;
    cycles(2);
    chk(!px_valid, "R9", px_valid, 0);
    cycles(1);

    // R9: drop enable with a burst in flight, stale words must be discarded
    pop_en = 1;
    start(32'h9000, 60, 4, 0, 0);
    for (int t = 0; t < 200 && n_acc < 1; t++) @(negedge clk);
    @(posedge clk); #1 en = 0; chk_on = 0;
    cycles(2);
    start(32'h9000, 60, 4, 0, 0);
    wait_fd(1);
    chk(n_fd == 1, "R9", n_fd, 1);
    chk(n_pal == 8, "R9", n_pal, 8);
    stop_fetch();

    // R8: underflow
    ufl_ie = 1;
    start(32'hA000, 40, 6, 0, 0);
    cycles(2);
    @(posedge clk); #1 force_pop = 1;
    @(posedge clk); #1 force_pop = 0;
    @(negedge clk);
    chk(ufl_flag && ufl_irq, "R8", {ufl_flag, ufl_irq}, 2'b11);
    @(posedge clk); #1 ufl_ie = 0;
    cycles(2);
    chk(ufl_flag && !ufl_irq, "R8", {ufl_flag, ufl_irq}, 2'b10);
    @(posedge clk); #1 ufl_clr = 1;
    @(posedge clk); #1 ufl_clr = 0;
    @(negedge clk);
    chk(!ufl_flag, "R8", ufl_flag, 0);
    @(posedge clk); #1 en = 0; chk_on = 0;
    @(posedge clk); #1 force_pop = 1;
    @(posedge clk); #1 force_pop = 0;
    cycles(2);
    chk(!ufl_flag, "R8", ufl_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule